// File: doc/BRIEF.md
# Pixel to decimal digit serializer

This block turns 8-bit pixel values into readable decimal text for a byte-wide serial transmitter. Each accepted pixel is split into its decimal digits by repeated division by ten. The block has its own sequential divider that returns both a quotient and a remainder. The remainders are gathered on a small last-in-first-out stack, so the digits leave most significant first as ASCII characters. A space delimiter follows each pixel. Leading zeros are never sent, and the value zero appears as a single `0`.

On the input side, a valid/ready handshake delivers pixels from the image memory. On the output side there is a byte bus, a one-cycle valid strobe and a busy input from the transmitter. The transmitter wraps each byte in a 10-bit frame with one start bit and one stop bit. A byte is only offered while busy is low, and never on two cycles in a row, so the transmitter always has one cycle to raise busy. The pixel width, the digit and delimiter codes, and whether a delimiter is sent are all parameters.

Top module: `pix_dec_ser`

## Requirements
- R1: After reset, pix_ready is 1 and tx_valid is 0.
- R2: Digits are sent as ASCII codes 0x30 plus the digit value, most significant digit first, with no leading zeros.
- R3: The pixel value 0 is sent as the single byte 0x30 followed by the delimiter.
- R4: Every pixel's digits are followed by exactly one delimiter byte, 0x20 by default.
- R5: tx_valid is 1 only in a cycle where tx_busy is 0.
- R6: tx_valid is never 1 in two consecutive cycles.
- R7: After a pixel is accepted (pix_valid and pix_ready both 1 at a clock edge), pix_ready stays 0 until the cycle after that pixel's delimiter strobe, and only then is a new pixel accepted.
- R8: Each division yields a quotient and a remainder with quotient*10+remainder equal to the dividend and remainder below 10, PIX_W cycles after it starts.
- R9: The digit stack never pushes when full and never pops when empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel offered |
| pix_data | input | PIX_W | Pixel value |
| pix_ready | output | 1 | Block can accept a pixel |
| tx_busy | input | 1 | Transmitter is sending a frame |
| tx_valid | output | 1 | One-cycle strobe for tx_byte |
| tx_byte | output | 8 | ASCII digit or delimiter |

## Verification
Some properties are checked by assertions on every cycle:
- the busy gate on the strobe and the one-cycle gap between strobes;
- the closing of the input handshake on acceptance and its reopening after the delimiter;
- the arithmetic identity of every divider result;
- the digit codes staying within 0x30..0x39;
- the stack staying within its bounds.

The exact character sequence of each pixel can only be shown by the bench's scenarios. That covers digit order, suppression of leading zeros, the lone zero digit and the placement of the delimiter. The bench compares the captured byte stream against decimal text that it formats itself, under transmitter busy periods of random length.

// File: rtl/pds_pkg.sv
package pds_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DIV_GO,
      ST_DIV_WAIT,
      ST_EMIT,
      ST_DELIM
   } pds_state_e;

   // number of decimal digits needed for the largest value of 'bits' bits
   function automatic int dec_digits(input int bits);
      int maxv;
      int n;
      maxv = (1 << bits) - 1;
      n    = 1;
      while (maxv >= 10) begin
         maxv = maxv / 10;
         n    = n + 1;
      end
      return n;
   endfunction

endpackage

// File: rtl/pds_divider.sv
module pds_divider #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic         busy,
   output logic         done,
   output logic [W-1:0] quotient,
   output logic [W-1:0] remainder
);
   localparam int CW = $clog2(W + 1);

   generate
      if (W < 2) begin : g_bad_w
         $error("pds_divider: W must be at least 2");
      end
   endgenerate

   logic [W-1:0]  q_r;
   logic [W-1:0]  r_r;
   logic [CW-1:0] cnt_r;
   logic          done_r;
   logic [W:0]    trial;
   logic [W:0]    diff;
   logic          borrow;

   always_comb begin
      trial  = {r_r, q_r[W-1]};
      diff   = trial - {1'b0, divisor};
      borrow = diff[W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_r    <= '0;
         r_r    <= '0;
         cnt_r  <= '0;
         done_r <= 1'b0;
      end else begin
         done_r <= 1'b0;
         if (start) begin
            q_r   <= dividend;
            r_r   <= '0;
            cnt_r <= CW'(W);
         end else if (cnt_r != '0) begin
            q_r   <= {q_r[W-2:0], ~borrow};
            r_r   <= borrow ? trial[W-1:0] : diff[W-1:0];
            cnt_r <= cnt_r - 1'b1;
            if (cnt_r == CW'(1)) done_r <= 1'b1;
         end
      end
   end

   assign busy      = (cnt_r != '0);
   assign done      = done_r;
   assign quotient  = q_r;
   assign remainder = r_r;

   assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);
   assert_nonzero_divisor_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (divisor != '0));

endmodule

// File: rtl/pds_digit_stack.sv
module pds_digit_stack #(
   parameter int DEPTH = 3,
   parameter int DW    = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic                       pop,
   input  logic [DW-1:0]              din,
   output logic [DW-1:0]              top,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic                       empty
);
   localparam int CNTW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("pds_digit_stack: DEPTH must be at least 1");
      end
   endgenerate

   logic [DW-1:0]   slot [DEPTH];
   logic [CNTW-1:0] cnt_r;

   genvar g;
   generate
      for (g = 0; g < DEPTH; g++) begin : g_slot
         logic [DW-1:0] from_below;
         logic [DW-1:0] from_above;
         if (g == 0) begin : g_first
            assign from_below = din;
         end else begin : g_rest
            assign from_below = slot[g-1];
         end
         if (g == DEPTH - 1) begin : g_last
            assign from_above = '0;
         end else begin : g_inner
            assign from_above = slot[g+1];
         end
         always_ff @(posedge clk) begin
            if (!rst_n) slot[g] <= '0;
            else if (push) slot[g] <= from_below;
            else if (pop) slot[g] <= from_above;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_r <= '0;
      else if (push && !pop) cnt_r <= cnt_r + 1'b1;
      else if (pop && !push) cnt_r <= cnt_r - 1'b1;
   end

   assign top   = slot[0];
   assign count = cnt_r;
   assign empty = (cnt_r == '0);

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (cnt_r < CNTW'(DEPTH)));
   assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
   assert_push_pop_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && pop));

endmodule

// File: rtl/pix_dec_ser.sv
module pix_dec_ser
   import pds_pkg::*;
#(
   parameter int         PIX_W      = 8,
   parameter logic [7:0] ZERO_CHAR  = 8'h30,
   parameter logic [7:0] DELIM_CHAR = 8'h20,
   parameter bit         DELIM_EN   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pix_valid,
   input  logic [PIX_W-1:0] pix_data,
   output logic             pix_ready,
   input  logic             tx_busy,
   output logic             tx_valid,
   output logic [7:0]       tx_byte
);
   localparam int NDIG = dec_digits(PIX_W);
   localparam int CNTW = $clog2(NDIG + 1);
   localparam pds_state_e AFTER_DIGITS = DELIM_EN ? ST_DELIM : ST_IDLE;

   generate
      if (PIX_W < 4 || PIX_W > 16) begin : g_bad_width
         $error("pix_dec_ser: PIX_W must lie in 4..16");
      end
   endgenerate

   pds_state_e       state_r;
   logic [PIX_W-1:0] work_r;
   logic             hold_r;

   logic             div_start;
   logic             div_busy;
   logic             div_done;
   logic [PIX_W-1:0] div_q;
   logic [PIX_W-1:0] div_r;

   logic [3:0]       stk_top;
   logic [CNTW-1:0]  stk_count;
   logic             stk_empty;

   logic             digit_fire;
   logic             delim_fire;

   assign div_start = (state_r == ST_DIV_GO);

   pds_divider #(.W(PIX_W)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (div_start),
      .dividend  (work_r),
      .divisor   (PIX_W'(10)),
      .busy      (div_busy),
      .done      (div_done),
      .quotient  (div_q),
      .remainder (div_r)
   );

   pds_digit_stack #(.DEPTH(NDIG), .DW(4)) u_stack (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (div_done),
      .pop   (digit_fire),
      .din   (div_r[3:0]),
      .top   (stk_top),
      .count (stk_count),
      .empty (stk_empty)
   );

   assign digit_fire = (state_r == ST_EMIT) && !tx_busy && !hold_r && !stk_empty;
   assign delim_fire = (state_r == ST_DELIM) && !tx_busy && !hold_r;
   assign tx_valid   = digit_fire || delim_fire;
   assign tx_byte    = (state_r == ST_EMIT) ? (ZERO_CHAR + {4'b0000, stk_top}) : DELIM_CHAR;
   assign pix_ready  = (state_r == ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_r <= ST_IDLE;
         work_r  <= '0;
         hold_r  <= 1'b0;
      end else begin
         hold_r <= tx_valid;
         unique case (state_r)
            ST_IDLE: begin
               if (pix_valid) begin
                  work_r  <= pix_data;
                  state_r <= ST_DIV_GO;
               end
            end
            ST_DIV_GO: state_r <= ST_DIV_WAIT;
            ST_DIV_WAIT: begin
               if (div_done) begin
                  if (div_q == '0) begin
                     state_r <= ST_EMIT;
                  end else begin
                     work_r  <= div_q;
                     state_r <= ST_DIV_GO;
                  end
               end
            end
            ST_EMIT: begin
               if (digit_fire && stk_count == CNTW'(1)) state_r <= AFTER_DIGITS;
            end
            ST_DELIM: begin
               if (delim_fire) state_r <= ST_IDLE;
            end
            default: state_r <= ST_IDLE;
         endcase
      end
   end

   assert_busy_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !tx_busy);
   assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |=> !tx_valid);
   assert_accept_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && pix_ready) |=> !pix_ready);
   assert_delim_reopens_R7: assert property (@(posedge clk) disable iff (!rst_n)
      delim_fire |=> pix_ready);
   assert_ascii_digit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      digit_fire |-> (tx_byte >= ZERO_CHAR && tx_byte <= ZERO_CHAR + 8'd9));
   assert_div_identity_R8: assert property (@(posedge clk) disable iff (!rst_n)
      div_done |-> ((32'(div_q) * 32'd10 + 32'(div_r) == 32'(work_r)) && (div_r < PIX_W'(10))));
   assert_div_idle_when_waiting_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_r == ST_EMIT) |-> !div_busy);

endmodule

// File: tb/tb_pix_dec_ser.sv
module tb_pix_dec_ser;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pix_valid = 1'b0;
   logic [7:0] pix_data = 8'd0;
   logic       pix_ready;
   logic       tx_busy;
   logic       tx_valid;
   logic [7:0] tx_byte;

   int         n_cmp = 0;
   int         n_bad = 0;
   int         cyc = 0;
   int         busy_cnt = 0;
   logic       prev_valid = 1'b0;
   logic [7:0] got[$];

   always #5 clk = ~clk;

   pix_dec_ser dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .pix_valid (pix_valid),
      .pix_data  (pix_data),
      .pix_ready (pix_ready),
      .tx_busy   (tx_busy),
      .tx_valid  (tx_valid),
      .tx_byte   (tx_byte)
   );

   // transmitter model: busy for a random time after each strobe
   always @(posedge clk) begin
      if (!rst_n) busy_cnt <= 0;
      else if (tx_valid) busy_cnt <= $urandom_range(0, 6);
      else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
   end
   assign tx_busy = (busy_cnt != 0);

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // output monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (tx_valid) begin
            got.push_back(tx_byte);
            check(!tx_busy, "R5 strobe while busy", int'(tx_busy), 0);
            check(!prev_valid, "R6 back-to-back strobe", int'(prev_valid), 0);
         end
         prev_valid = tx_valid;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   function automatic string expect_text(input int v);
      return $sformatf("%0d ", v);
   endfunction

   task automatic send(input int v);
      string s;
      s = expect_text(v);
      got.delete();
      while (!pix_ready) @(negedge clk);
      pix_valid = 1'b1;
      pix_data  = 8'(v);
      @(negedge clk);
      pix_valid = 1'b0;
      pix_data  = 8'($urandom_range(0, 255));   // must be ignored while busy
      check(!pix_ready, "R7 ready low after accept", int'(pix_ready), 0);
      while (!pix_ready) @(negedge clk);
      check(got.size() == s.len(), "R7 byte count before ready", got.size(), s.len());
      for (int i = 0; i < s.len() && i < got.size(); i++) begin
         if (i == s.len() - 1)
            check(got[i] == 8'h20, "R4 delimiter", int'(got[i]), 32);
         else if (v == 0)
            check(got[i] == 8'h30, "R3 zero digit", int'(got[i]), 48);
         else
            check(got[i] == 8'(s[i]), "R2 digit", int'(got[i]), int'(s[i]));
      end
   endtask

   initial begin
      int dir[] = '{0, 9, 10, 99, 100, 255, 1, 200, 101, 50};
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(pix_ready == 1'b1, "R1 ready after reset", int'(pix_ready), 1);
      check(tx_valid == 1'b0, "R1 no strobe after reset", int'(tx_valid), 0);
      foreach (dir[i]) send(dir[i]);   // R8 exercised through every digit
      for (int k = 0; k < 60; k++) send($urandom_range(0, 255));
      repeat (5) @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule